// File: doc/BRIEF.md
# Configurable Pin-to-Matrix Port Cell

This block is a single configurable port that joins one external pin to one line of an internal switch matrix. A 4-bit mode code is loaded into a mode register on every clock edge. That code selects how the cell behaves:

- a buffer in either direction, with or without a register;
- a two-way transceiver;
- a self-steering open-drain repeater;
- a driver that holds the pin low or high;
- a driver that holds the matrix line low;
- an isolated cell with both drivers off.

Each driver is modelled with separate data and drive-enable signals, so the block needs no tri-state logic. The integrating chip performs the wired resolution of the pin and the line outside this cell.

Optional enables qualify the two directions. A pin-side enable is called `oe` and a line-side enable is called `ie`; a port that does not use one ties it high. An `invert` bit flips the outgoing pin data in the modes that support inversion.

The pin and the line are level signals that are sampled continuously. The block therefore has no valid/ready handshake and no back-pressure. Mode, enables and inversion are plain control pins.

When a driver is released, its data output reads 0.

Top module: `io_port_cell`

## Requirements
- R1: Reset is synchronous and active high. Reset loads the isolated code 0 and clears both data registers. Code 0, and every code from 10 to 15, releases both drivers: `pin_oe`=0 and `line_drive`=0, with `pin_out`=0 and `line_out`=0.
- R2: Code 1 (pin to line): `line_drive`=`ie` and `line_out`=`pin_in`. The pin is not driven.
- R3: Code 2 (line to pin): `pin_oe`=`oe` and `pin_out`=`line_in` XOR `invert`. The line is not driven.
- R4: Code 3 (registered pin to line): at each edge with this code registered and `ie`=1, the capture register loads `pin_in`. With `ie`=0 the register holds its value. The line is always driven with the register value.
- R5: Code 4 (registered line to pin): the pin shows the value `line_in` had at the previous edge, gated by `oe`. `invert` has no effect in this code.
- R6: Code 5 (transceiver): the line takes `pin_in` under `ie`, and the pin takes `line_in` XOR `invert` under `oe`, both at once.
- R7: Code 6 (repeater): in the cycle after an edge that sees `pin_in` low while the cell is idle, the cell drives the line low. If instead it sees `line_in` low while idle, the cell drives the pin low in the next cycle. Each low is released one edge after its source goes high. Only the value 0 is ever driven in this code.
- R8: Code 6 (repeater): a cell that drives the line low never drives its own pin low, and a cell that drives its pin low never drives the line. The cell keeps sourcing the line for as long as its pin stays low, so two repeaters on one line cannot hold each other low.
- R9: Code 7 drives the pin to 0 and code 8 drives it to 1, each gated by `oe`, whatever `line_in` is.
- R10: Code 9 drives the line to 0 under `ie`, whatever `pin_in` is.
- R11: The `mode` input is registered. A new code takes effect in the cycle after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 4 | Function code, registered every edge |
| invert | input | 1 | Invert outgoing pin data (codes 2 and 5) |
| ie | input | 1 | Line-side enable or capture enable; tie high if unused |
| oe | input | 1 | Pin driver enable; tie high if unused |
| pin_in | input | 1 | Resolved level seen at the pin |
| pin_out | output | 1 | Pin driver data |
| pin_oe | output | 1 | Pin driver enable |
| line_in | input | 1 | Resolved level of the matrix line |
| line_out | output | 1 | Line driver data |
| line_drive | output | 1 | Line driver enable |

## Verification
The assertions assume that `pin_in` and `line_in` are the resolved wired values, and that in repeater code a driven 0 really pulls them low. They also assume that the inputs settle between edges. The stimulus changes inputs only on the falling clock edge. It reaches repeater code only through a bench model in which two cells share one wired-AND line and each pin folds the cell's own low drive back into `pin_in`. Random phases apply every other code, including the unused codes, with the second cell isolated, so no combinational path loops through the pin.

// File: rtl/io_port_pkg.sv
package io_port_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    M_NC     = 4'd0,
    M_IN     = 4'd1,
    M_OUT    = 4'd2,
    M_RIN    = 4'd3,
    M_ROUT   = 4'd4,
    M_XCVR   = 4'd5,
    M_REPEAT = 4'd6,
    M_PLOW   = 4'd7,
    M_PHIGH  = 4'd8,
    M_LLOW   = 4'd9
  } port_mode_e;

  typedef struct packed {
    logic pin_en;
    logic pin_val;
    logic line_en;
    logic line_val;
  } drive_s;
endpackage

// File: rtl/io_port_regs.sv
module io_port_regs
  import io_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              ie,
  input  logic              pin_in,
  input  logic              line_in,
  output logic [MODE_W-1:0] mode_q,
  output logic              in_q,
  output logic              out_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= M_NC;
      in_q   <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      mode_q <= mode;
      out_q  <= line_in;
      if (mode_q == M_RIN && ie) in_q <= pin_in;
    end
  end

  logic started;
  always_ff @(posedge clk) begin
    if (rst) started <= 1'b0;
    else     started <= 1'b1;
  end

  assert_mode_follow_R11: assert property (@(posedge clk) disable iff (rst)
    started |-> mode_q == $past(mode));

  assert_ro_capture_R5: assert property (@(posedge clk) disable iff (rst)
    started |-> out_q == $past(line_in));

  assert_ri_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (started && !($past(mode_q) == M_RIN && $past(ie))) |-> $stable(in_q));
endmodule

// File: rtl/io_port_repeater.sv
module io_port_repeater (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pin_in,
  input  logic line_in,
  output logic pin_low,
  output logic line_low
);
  typedef enum logic [1:0] {RP_IDLE, RP_FROM_PIN, RP_FROM_LINE} rp_state_e;
  rp_state_e st, st_nx;

  always_comb begin
    st_nx = st;
    if (!en) st_nx = RP_IDLE;
    else begin
      unique case (st)
        RP_IDLE: begin
          if (!pin_in)       st_nx = RP_FROM_PIN;
          else if (!line_in) st_nx = RP_FROM_LINE;
        end
        RP_FROM_PIN:  if (pin_in)  st_nx = RP_IDLE;
        RP_FROM_LINE: if (line_in) st_nx = RP_IDLE;
        default:      st_nx = RP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= RP_IDLE;
    else     st <= st_nx;
  end

  // the "sourced here" flag is the RP_FROM_PIN state
  assign line_low = (st == RP_FROM_PIN);
  assign pin_low  = (st == RP_FROM_LINE);

  assert_br_pin_to_line_R7: assert property (@(posedge clk) disable iff (rst)
    (en && st == RP_IDLE && !pin_in) |=> (line_low || !en));

  assert_br_keep_source_R8: assert property (@(posedge clk) disable iff (rst)
    (en && line_low && !pin_in) |=> (line_low || !en));
endmodule

// File: rtl/io_port_route.sv
module io_port_route
  import io_port_pkg::*;
(
  input  logic [MODE_W-1:0] mode_q,
  input  logic              invert,
  input  logic              ie,
  input  logic              oe,
  input  logic              pin_in,
  input  logic              line_in,
  input  logic              in_q,
  input  logic              out_q,
  input  logic              rp_pin_low,
  input  logic              rp_line_low,
  output drive_s            drv
);
  drive_s raw;

  always_comb begin
    raw = '0;
    case (mode_q)
      M_IN: begin
        raw.line_en  = ie;
        raw.line_val = pin_in;
      end
      M_OUT: begin
        raw.pin_en  = oe;
        raw.pin_val = line_in ^ invert;
      end
      M_RIN: begin
        raw.line_en  = 1'b1;
        raw.line_val = in_q;
      end
      M_ROUT: begin
        raw.pin_en  = oe;
        raw.pin_val = out_q;
      end
      M_XCVR: begin
        raw.line_en  = ie;
        raw.line_val = pin_in;
        raw.pin_en   = oe;
        raw.pin_val  = line_in ^ invert;
      end
      M_REPEAT: begin
        raw.pin_en  = rp_pin_low;
        raw.line_en = rp_line_low;
      end
      M_PLOW:  raw.pin_en = oe;
      M_PHIGH: begin
        raw.pin_en  = oe;
        raw.pin_val = 1'b1;
      end
      M_LLOW:  raw.line_en = ie;
      default: raw = '0;
    endcase
  end

  always_comb begin
    drv          = raw;
    drv.pin_val  = raw.pin_val & raw.pin_en;
    drv.line_val = raw.line_val & raw.line_en;
  end
endmodule

// File: rtl/io_port_cell.sv
module io_port_cell
  import io_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              invert,
  input  logic              ie,
  input  logic              oe,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe,
  input  logic              line_in,
  output logic              line_out,
  output logic              line_drive
);
  logic [MODE_W-1:0] mode_q;
  logic in_q, out_q, rp_pin_low, rp_line_low;
  drive_s drv;

  io_port_regs u_regs (
    .clk(clk), .rst(rst), .mode(mode), .ie(ie), .pin_in(pin_in),
    .line_in(line_in), .mode_q(mode_q), .in_q(in_q), .out_q(out_q)
  );

  io_port_repeater u_rep (
    .clk(clk), .rst(rst), .en(mode_q == M_REPEAT), .pin_in(pin_in),
    .line_in(line_in), .pin_low(rp_pin_low), .line_low(rp_line_low)
  );

  io_port_route u_route (
    .mode_q(mode_q), .invert(invert), .ie(ie), .oe(oe), .pin_in(pin_in),
    .line_in(line_in), .in_q(in_q), .out_q(out_q), .rp_pin_low(rp_pin_low),
    .rp_line_low(rp_line_low), .drv(drv)
  );

  assign pin_oe     = drv.pin_en;
  assign pin_out    = drv.pin_val;
  assign line_drive = drv.line_en;
  assign line_out   = drv.line_val;

  assert_nc_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_NC || mode_q > M_LLOW) |-> (!pin_oe && !line_drive));

  assert_force_high_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_PHIGH && oe) |-> (pin_oe && pin_out));

  assert_br_one_side_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_REPEAT) |-> !(pin_oe && line_drive));

  assert_br_low_only_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_REPEAT) |-> (!pin_out && !line_out));
endmodule

// File: tb/sim_io_port_cell.sv
module sim_io_port_cell;
  localparam int P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] tb_mode0 = 4'd0, tb_mode1 = 4'd0;
  logic tb_inv = 1'b0, tb_ie = 1'b1, tb_oe = 1'b1;
  logic tb_pin0 = 1'b1, tb_pin1 = 1'b1, tb_line = 1'b1;
  logic share = 1'b0, loop0 = 1'b0;
  logic pin_out0, pin_oe0, line_out0, line_drive0;
  logic pin_out1, pin_oe1, line_out1, line_drive1;
  logic pin_in0, pin_in1, line_in0, wired;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(P/2) clk = ~clk;

  assign wired   = (line_drive0 ? line_out0 : 1'b1) & (line_drive1 ? line_out1 : 1'b1) & tb_line;
  assign line_in0 = share ? wired : tb_line;
  assign pin_in0 = tb_pin0 & ~(loop0 & pin_oe0 & ~pin_out0);
  assign pin_in1 = tb_pin1 & ~(pin_oe1 & ~pin_out1);

  io_port_cell u0 (
    .clk(clk), .rst(rst), .mode(tb_mode0), .invert(tb_inv), .ie(tb_ie), .oe(tb_oe),
    .pin_in(pin_in0), .pin_out(pin_out0), .pin_oe(pin_oe0),
    .line_in(line_in0), .line_out(line_out0), .line_drive(line_drive0)
  );

  io_port_cell u1 (
    .clk(clk), .rst(rst), .mode(tb_mode1), .invert(tb_inv), .ie(tb_ie), .oe(tb_oe),
    .pin_in(pin_in1), .pin_out(pin_out1), .pin_oe(pin_oe1),
    .line_in(wired), .line_out(line_out1), .line_drive(line_drive1)
  );

  // reference state of u0, built only from the bench inputs
  logic [3:0] m_mode = 4'd0;
  logic m_in = 1'b0, m_out = 1'b0;
  always @(posedge clk) begin
    if (rst) begin
      m_mode <= 4'd0; m_in <= 1'b0; m_out <= 1'b0;
    end else begin
      m_mode <= tb_mode0;
      m_out  <= tb_line;
      if (m_mode == 4'd3 && tb_ie) m_in <= tb_pin0;
    end
  end

  // returns {pin_oe, pin_out, line_drive, line_out}
  function automatic logic [3:0] expect_drv(logic [3:0] md, logic inv, logic ie, logic oe,
                                            logic pin, logic line, logic rin, logic rout);
    logic pe, pv, le, lv;
    pe = 0; pv = 0; le = 0; lv = 0;
    case (md)
      4'd1: begin le = ie; lv = pin; end
      4'd2: begin pe = oe; pv = line ^ inv; end
      4'd3: begin le = 1; lv = rin; end
      4'd4: begin pe = oe; pv = rout; end
      4'd5: begin le = ie; lv = pin; pe = oe; pv = line ^ inv; end
      4'd7: pe = oe;
      4'd8: begin pe = oe; pv = 1; end
      4'd9: le = ie;
      default: ;
    endcase
    return {pe, pv & pe, le, lv & le};
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b mode=%0d t=%0t", req, act, exp, m_mode, $time);
    end
  endtask

  function automatic logic [3:0] act0();
    return {pin_oe0, pin_out0, line_drive0, line_out0};
  endfunction

  function automatic logic [3:0] model0();
    return expect_drv(m_mode, tb_inv, tb_ie, tb_oe, tb_pin0, tb_line, m_in, m_out);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(P * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) act=hung exp=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state
    tb_mode0 = 4'd2;
    repeat (3) tick();
    check("R1 reset", act0(), 4'b0000);
    @(negedge clk); rst = 0; tb_mode0 = 4'd12;
    tick(); tick();
    check("R1 unused code 12", act0(), 4'b0000);

    // R11: code takes effect after the next edge
    @(negedge clk); tb_mode0 = 4'd2; tb_line = 1; tb_inv = 0; tb_oe = 1;
    #1 check("R11 before edge", act0(), 4'b0000);
    tick();
    check("R11 after edge", act0(), 4'b1100);

    // R3: inversion
    @(negedge clk); tb_inv = 1; #1;
    check("R3 invert", act0(), 4'b1000);

    // R4: capture then hold with ie low
    @(negedge clk); tb_mode0 = 4'd3; tb_ie = 1; tb_pin0 = 1;
    tick(); tick();
    check("R4 capture one", act0(), 4'b0011);
    @(negedge clk); tb_ie = 0; tb_pin0 = 0;
    tick(); tick();
    check("R4 hold with ie low", act0(), 4'b0011);

    // R5: registered output ignores invert
    @(negedge clk); tb_mode0 = 4'd4; tb_inv = 1; tb_oe = 1; tb_line = 1;
    tick(); tick();
    check("R5 invert ignored", act0(), 4'b1100);
    @(negedge clk); tb_line = 0;
    #1 check("R5 before edge", act0(), 4'b1100);
    tick();
    check("R5 after edge", act0(), 4'b1000);

    // R9 / R10 directed
    @(negedge clk); tb_mode0 = 4'd8; tb_line = 0; tb_oe = 1; tick();
    check("R9 force high", act0(), 4'b1100);
    @(negedge clk); tb_mode0 = 4'd9; tb_ie = 1; tb_pin0 = 1; tick();
    check("R10 line force low", act0(), 4'b0010);

    // random phase over codes other than 6 (R1..R6, R9, R10)
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      tb_mode0 = 4'($urandom_range(0, 15));
      if (tb_mode0 == 4'd6) tb_mode0 = 4'd0;
      tb_inv = 1'($urandom); tb_ie = 1'($urandom); tb_oe = 1'($urandom);
      tb_pin0 = 1'($urandom); tb_line = 1'($urandom);
      tick();
      check("R1-R6/R9/R10 random: R2 R3 R6", act0(), model0());
    end

    // repeater: two cells on one wired-AND line (R7, R8)
    @(negedge clk);
    tb_mode0 = 4'd6; tb_mode1 = 4'd6; share = 1; loop0 = 1;
    tb_line = 1; tb_pin0 = 1; tb_pin1 = 1; tb_inv = 1;
    tick(); tick(); tick();
    check("R7 repeater idle", {pin_oe0, line_drive0, pin_oe1, line_drive1}, 4'b0000);
    @(negedge clk); tb_pin0 = 0;
    tick();
    check("R7 pin low to line", {line_drive0, line_out0, wired}, 3'b100);
    tick();
    check("R7 line low to other pin", {pin_oe1, pin_out1, pin_in1}, 3'b100);
    repeat (4) tick();
    check("R8 no own-pin drive", {pin_oe0, line_drive1, line_drive0}, 3'b001);
    @(negedge clk); tb_pin0 = 1;
    repeat (3) tick();
    check("R7 release both sides",
          {pin_oe0, line_drive0, pin_oe1, line_drive1, wired, pin_in0, pin_in1}, 7'b0000111);
    @(negedge clk); tb_pin1 = 0;
    tick(); tick();
    check("R7 reverse direction", {line_drive1, pin_oe0, pin_in0, pin_oe1}, 4'b1100);
    @(negedge clk); tb_pin1 = 1;
    repeat (3) tick();
    check("R8 no latched low", {pin_oe0, line_drive0, pin_oe1, line_drive1, wired}, 5'b00001);
    @(negedge clk); tb_line = 0;
    tick();
    check("R7 external line low", {pin_oe0, pin_oe1, line_drive0, line_drive1}, 4'b1100);
    @(negedge clk); tb_line = 1;
    repeat (3) tick();
    check("R7 external release", {pin_oe0, pin_oe1, pin_in0, pin_in1}, 4'b0011);

    done = 1;
    finish_run();
  end
endmodule